// File: doc/BRIEF.md
# Scaled-Index Add Execution Unit

This unit executes two integer instructions that each read two source registers and write one. Both scale one operand by a small power of two and add it to a 64-bit base. The full variant scales the whole 64-bit index operand. The word variant scales only the low 32 bits of the index operand, treated as unsigned, and adds the result to the full 64-bit base. The typical use is forming an address from a base pointer and an element index in a single operation.

The unit decodes a 32-bit instruction word and samples the two operand values when `in_valid` is high. One clock later it presents the 64-bit sum, the register indices the instruction named, and a valid flag. When the instruction's record bit is set, it also presents a 4-bit condition field and a write enable for that field. The primary opcode and the two extended opcode values are parameters. An instruction word that matches neither variant produces no result.

Top module: `scaled_add_unit`

## Requirements
- R1: An instruction is accepted only when insn[31:26] equals PRIM_OP and insn[8:1] equals XO_FULL (full variant) or XO_WORD (word variant). An accepted instruction raises `out_valid` for exactly one cycle, on the clock edge after the edge that sampled it with `in_valid` high.
- R2: The scale selector is insn[10:9]. The shift distance is the selector plus one, so the values 0, 1, 2 and 3 multiply the index operand by 2, 4, 8 and 16. No selector value gives a factor of 1.
- R3: The full variant produces `result` = (`index_in` << shift) + `base_in`.
- R4: The word variant takes only `index_in[31:0]`, zero-extends it to 64 bits, shifts it in a 64-bit path (bits moved above bit 31 are kept) and adds the full 64-bit `base_in`. `index_in[63:32]` has no effect on the result.
- R5: The sum is kept modulo 2^64. Any carry out of bit 63 is dropped and nothing reports it.
- R6: For an accepted instruction, `dst_idx` = insn[25:21], `src_a_idx` = insn[20:16] (the base register) and `src_b_idx` = insn[15:11] (the scaled register).
- R7: A cycle with `in_valid` low, or with an instruction word that matches neither variant, gives `out_valid` and `cond_we` low on the next cycle. In that case `result`, `dst_idx`, `src_a_idx` and `src_b_idx` keep their previous values.
- R8: When the record bit insn[0] is 1, `cond_we` goes high together with `out_valid`. `cond_bits` is then {LT, GT, EQ, SO} in bit order 3 down to 0. With the 64-bit result read as a signed value, LT is set when the result is negative, GT when it is positive and non-zero, and EQ when it is zero. Exactly one of the three is set.
- R9: When the record bit is 0, `cond_we` stays low for that instruction.
- R10: `cond_bits[0]` equals `so_in` as sampled together with the instruction.
- R11: While `rst` is high at a clock edge, `out_valid` and `cond_we` are cleared and `result` is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| insn | input | 32 | Instruction word |
| base_in | input | 64 | Value of the base source register |
| index_in | input | 64 | Value of the scaled source register |
| so_in | input | 1 | Summary-overflow value to copy into the condition field |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Scaled sum |
| dst_idx | output | 5 | Destination register index |
| src_a_idx | output | 5 | Base register index that was read |
| src_b_idx | output | 5 | Scaled register index that was read |
| cond_we | output | 1 | Condition field write enable |
| cond_bits | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions check properties that must hold on every cycle:
- the one-cycle relation between `in_valid` and `out_valid`;
- `cond_we` is never high without `out_valid`;
- exactly one of LT, GT and EQ is set, and LT and EQ agree with the registered result;
- the scaled operand never has bit 0 set;
- in the word variant, the scaled operand never has bits above bit 35 set.

The arithmetic values themselves, and the fact that the upper word of the index operand has no effect, can only be shown by the bench's scenarios. These cover every selector value for both variants, wrap past 2^64, rejected opcodes, and zero, negative and positive results with the record bit set.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int SEL_W     = 2;
  localparam int PO_W      = 6;
  localparam int XO_W      = 8;
  localparam int CR_W      = 4;

  typedef enum logic [1:0] {
    SAU_NONE = 2'd0,
    SAU_FULL = 2'd1,
    SAU_WORD = 2'd2
  } sau_kind_e;

  typedef struct packed {
    sau_kind_e              kind;
    logic [REG_IDX_W-1:0]   dst;
    logic [REG_IDX_W-1:0]   src_a;
    logic [REG_IDX_W-1:0]   src_b;
    logic [SEL_W-1:0]       sel;
    logic                   rec;
  } sau_dec_t;
endpackage

// File: rtl/sau_decode.sv
module sau_decode
  import sau_pkg::*;
#(
  parameter logic [PO_W-1:0] PRIM_OP = 6'd22,
  parameter logic [XO_W-1:0] XO_FULL = 8'd110,
  parameter logic [XO_W-1:0] XO_WORD = 8'd111
) (
  input  logic [INSN_W-1:0] insn,
  output sau_dec_t          dec
);
  // Fields are numbered big-endian (bit 0 = MSB); convert to vector indices.
  localparam int PO_HI  = INSN_W - 1;
  localparam int PO_LO  = PO_HI - PO_W + 1;
  localparam int DST_HI = PO_LO - 1;
  localparam int DST_LO = DST_HI - REG_IDX_W + 1;
  localparam int SA_HI  = DST_LO - 1;
  localparam int SA_LO  = SA_HI - REG_IDX_W + 1;
  localparam int SB_HI  = SA_LO - 1;
  localparam int SB_LO  = SB_HI - REG_IDX_W + 1;
  localparam int SEL_HI = SB_LO - 1;
  localparam int SEL_LO = SEL_HI - SEL_W + 1;
  localparam int XO_HI  = SEL_LO - 1;
  localparam int XO_LO  = XO_HI - XO_W + 1;
  localparam int REC_B  = XO_LO - 1;

  logic [PO_W-1:0] po_f;
  logic [XO_W-1:0] xo_f;

  always_comb begin
    po_f      = insn[PO_HI:PO_LO];
    xo_f      = insn[XO_HI:XO_LO];
    dec.dst   = insn[DST_HI:DST_LO];
    dec.src_a = insn[SA_HI:SA_LO];
    dec.src_b = insn[SB_HI:SB_LO];
    dec.sel   = insn[SEL_HI:SEL_LO];
    dec.rec   = insn[REC_B];
    dec.kind  = SAU_NONE;
    if (po_f == PRIM_OP) begin
      if (xo_f == XO_FULL)      dec.kind = SAU_FULL;
      else if (xo_f == XO_WORD) dec.kind = SAU_WORD;
    end
  end
endmodule

// File: rtl/sau_shift_add.sv
module sau_shift_add
  import sau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sau_kind_e         kind,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] index,
  output logic [DATA_W-1:0] sum
);
  localparam int N_SCALE   = 2 ** SEL_W;
  localparam int WORD_SPAN = WORD_W + N_SCALE;

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] cand [N_SCALE];

  always_comb begin
    if (kind == SAU_WORD) operand = {{(DATA_W-WORD_W){1'b0}}, index[WORD_W-1:0]};
    else                  operand = index;
  end

  // One candidate per selector value; shift distance is selector + 1.
  for (genvar k = 0; k < N_SCALE; k++) begin : g_scale
    assign cand[k] = operand << (k + 1);
  end

  assign scaled = cand[sel];
  assign sum    = scaled + base;

  // R2
  scale_never_one_chk: assert property (@(posedge clk) disable iff (rst)
    (kind != SAU_NONE) |-> (scaled[0] == 1'b0));

  // R4
  word_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == SAU_WORD) |-> (scaled[DATA_W-1:WORD_SPAN] == '0));
endmodule

// File: rtl/sau_cond.sv
module sau_cond
  import sau_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic              so,
  output logic [CR_W-1:0]   flags
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (value == '0);
    is_neg  = value[DATA_W-1];
    flags   = {is_neg, !is_neg && !is_zero, is_zero, so};
  end
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
  import sau_pkg::*;
#(
  parameter int              DATA_W  = 64,
  parameter int              WORD_W  = 32,
  parameter logic [PO_W-1:0] PRIM_OP = 6'd22,
  parameter logic [XO_W-1:0] XO_FULL = 8'd110,
  parameter logic [XO_W-1:0] XO_WORD = 8'd111
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    insn,
  input  logic [DATA_W-1:0]    base_in,
  input  logic [DATA_W-1:0]    index_in,
  input  logic                 so_in,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    result,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [REG_IDX_W-1:0] src_a_idx,
  output logic [REG_IDX_W-1:0] src_b_idx,
  output logic                 cond_we,
  output logic [CR_W-1:0]      cond_bits
);
  sau_dec_t          dec;
  logic [DATA_W-1:0] sum;
  logic [CR_W-1:0]   flags;
  logic              accept;

  sau_decode #(
    .PRIM_OP (PRIM_OP),
    .XO_FULL (XO_FULL),
    .XO_WORD (XO_WORD)
  ) u_decode (
    .insn (insn),
    .dec  (dec)
  );

  sau_shift_add #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) u_shift_add (
    .clk   (clk),
    .rst   (rst),
    .kind  (dec.kind),
    .sel   (dec.sel),
    .base  (base_in),
    .index (index_in),
    .sum   (sum)
  );

  sau_cond #(
    .DATA_W (DATA_W)
  ) u_cond (
    .value (sum),
    .so    (so_in),
    .flags (flags)
  );

  assign accept = in_valid && (dec.kind != SAU_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cond_we   <= 1'b0;
      result    <= '0;
      dst_idx   <= '0;
      src_a_idx <= '0;
      src_b_idx <= '0;
      cond_bits <= '0;
    end else begin
      out_valid <= accept;
      cond_we   <= accept && dec.rec;
      if (accept) begin
        result    <= sum;
        dst_idx   <= dec.dst;
        src_a_idx <= dec.src_a;
        src_b_idx <= dec.src_b;
        cond_bits <= flags;
      end
    end
  end

  // R1
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> (!out_valid |-> $stable(result)));

  // R9
  cond_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> out_valid);

  // R8
  cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> ($countones(cond_bits[3:1]) == 1));

  // R8
  cond_eq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> (cond_bits[1] == (result == '0)));

  // R8
  cond_lt_sign_chk: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> (cond_bits[3] == result[DATA_W-1]));
endmodule

// File: tb/scaled_add_unit_tb.sv
module scaled_add_unit_tb;
  localparam logic [5:0] PO = 6'd22;
  localparam logic [7:0] XF = 8'd110;
  localparam logic [7:0] XW = 8'd111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] base_in = '0;
  logic [63:0] index_in = '0;
  logic        so_in = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  dst_idx, src_a_idx, src_b_idx;
  logic        cond_we;
  logic [3:0]  cond_bits;

  always #2 clk = ~clk;

  scaled_add_unit #(
    .DATA_W (64), .WORD_W (32),
    .PRIM_OP (PO), .XO_FULL (XF), .XO_WORD (XW)
  ) u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .insn (insn),
    .base_in (base_in), .index_in (index_in), .so_in (so_in),
    .out_valid (out_valid), .result (result), .dst_idx (dst_idx),
    .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
    .cond_we (cond_we), .cond_bits (cond_bits)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  d, sa, sb;
    logic        we;
    logic [3:0]  cb;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] last_res = '0;
  logic [3:0]  last_cb = '0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] d, logic [4:0] sa,
                                     logic [4:0] sb, logic [1:0] sel, logic [7:0] xo,
                                     logic rec);
    return {po, d, sa, sb, sel, xo, rec};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one instruction and pushes its expected outcome.
  task automatic drive(logic [31:0] w, logic [63:0] a, logic [63:0] b, logic so, string tag);
    exp_t        e;
    logic [63:0] op;
    logic [63:0] r;
    int          sh;
    bit          full, word;
    @(negedge clk);
    in_valid = 1'b1; insn = w; base_in = a; index_in = b; so_in = so;
    full = (w[31:26] == PO) && (w[8:1] == XF);
    word = (w[31:26] == PO) && (w[8:1] == XW);
    if (full || word) begin
      sh = int'(w[10:9]) + 1;
      op = word ? {32'h0, b[31:0]} : b;
      r  = (op << sh) + a;
      e.res = r; e.d = w[25:21]; e.sa = w[20:16]; e.sb = w[15:11];
      e.we  = w[0];
      if ($signed(r) < 0)      e.cb = {3'b100, so};
      else if (r == 64'd0)     e.cb = {3'b001, so};
      else                     e.cb = {3'b010, so};
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.res, {e.tag, " result"}, result, e.res);
          chk({dst_idx, src_a_idx, src_b_idx} == {e.d, e.sa, e.sb}, "R6 indices",
              {49'h0, dst_idx, src_a_idx, src_b_idx}, {49'h0, e.d, e.sa, e.sb});
          chk(cond_we == e.we, e.we ? "R8 cond_we" : "R9 cond_we",
              {63'h0, cond_we}, {63'h0, e.we});
          if (e.we)
            chk(cond_bits == e.cb, "R8 R10 cond_bits", {60'h0, cond_bits}, {60'h0, e.cb});
          last_res = e.res;
        end
      end else begin
        chk(result == last_res && cond_we == 1'b0, "R7 hold while idle or rejected",
            result, last_res);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0 && cond_we == 1'b0 && result == 64'd0, "R11 reset state",
        result, 64'd0);

    // R2 R3: every selector, full variant, back to back
    for (int s = 0; s < 4; s++)
      drive(mk(PO, 5'd3, 5'd4, 5'd5, 2'(s), XF, 1'b0),
            64'h0000_0000_0000_1000, 64'hFFFF_FFFF_8000_0001, 1'b0, "R2 R3 full scale");
    idle(2);

    // R2 R4: every selector, word variant, upper index word set and ignored
    for (int s = 0; s < 4; s++)
      drive(mk(PO, 5'd7, 5'd8, 5'd9, 2'(s), XW, 1'b0),
            64'h1000_0000_0000_0000, 64'hDEAD_BEEF_F000_0003, 1'b0, "R2 R4 word scale");
    idle(2);

    // R4: bits moved above bit 31 kept; two index values differing only in upper word
    drive(mk(PO, 5'd1, 5'd2, 5'd3, 2'd3, XW, 1'b0), 64'd0, 64'h0000_0000_F000_0000,
          1'b0, "R4 no truncation");
    drive(mk(PO, 5'd1, 5'd2, 5'd3, 2'd3, XW, 1'b0), 64'd0, 64'hFFFF_FFFF_F000_0000,
          1'b0, "R4 upper word ignored");
    idle(2);

    // R5: wrap past 2^64 to zero with record bit -> EQ
    drive(mk(PO, 5'd10, 5'd11, 5'd12, 2'd0, XF, 1'b1), 64'hFFFF_FFFF_FFFF_FFF0, 64'd8,
          1'b0, "R5 R8 wrap to zero");
    drive(mk(PO, 5'd10, 5'd11, 5'd12, 2'd1, XF, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
          1'b1, "R5 R10 wrap positive");
    // R8 negative with SO set, positive without
    drive(mk(PO, 5'd13, 5'd14, 5'd15, 2'd0, XF, 1'b1), 64'd0, 64'h4000_0000_0000_0000,
          1'b1, "R8 R10 negative");
    drive(mk(PO, 5'd16, 5'd17, 5'd18, 2'd2, XW, 1'b1), 64'd5, 64'h8000_0000_0000_0002,
          1'b0, "R8 positive");
    idle(2);

    // R1 R7: rejected words (wrong primary, wrong extended) then hold
    drive(mk(PO, 5'd20, 5'd21, 5'd22, 2'd0, XF, 1'b1), 64'd100, 64'd1, 1'b0, "R3 before reject");
    drive(mk(PO ^ 6'd1, 5'd1, 5'd1, 5'd1, 2'd0, XF, 1'b1), 64'hAAAA, 64'h5555, 1'b0, "R1 bad po");
    drive(mk(PO, 5'd1, 5'd1, 5'd1, 2'd0, 8'd109, 1'b1), 64'hAAAA, 64'h5555, 1'b0, "R1 bad xo");
    idle(3);

    // R9: record bit clear
    drive(mk(PO, 5'd31, 5'd0, 5'd30, 2'd1, XF, 1'b0), 64'd0, 64'd0, 1'b1, "R9 no record");
    idle(2);

    // Mixed pseudo-random stream
    for (int i = 0; i < 200; i++) begin
      logic [63:0] a, b;
      logic [31:0] w;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = seed;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = seed;
      w = mk(PO, a[4:0], a[9:5], b[4:0], b[6:5], b[7] ? XW : XF, a[12]);
      if (a[20:18] == 3'd0) w[31:26] = ~PO;
      drive(w, a, b, b[9], "R3 R4 R8 random");
      if (b[11:10] == 2'd0) idle(1);
    end
    idle(4);

    chk(q.size() == 0, "R1 scoreboard drained", 64'(q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule